// File: doc/BRIEF.md
# Serial NOR Page Program Sequencer

This block is a hardware master that writes a run of bytes of any length into a serial NOR flash over a single-lane SPI link. A client gives a start offset and a byte count with a one-cycle start strobe, then supplies the bytes through a valid/ready stream. The sequencer splits the run so that no program command crosses a flash page boundary. For each piece it sends a write-enable command, then a page-program command with a 24-bit address and the data.

After each piece the sequencer reads the flash's flag status byte over and over until the device reports ready. It then inspects the error bits. If any error bit is set, it clears the flags, drops the rest of the run and ends with an error result. If no error bit is set, it moves on to the next piece. When the run ends, a one-cycle done pulse is raised and the result flag is held until the next start.

Top module: `nor_page_prog`

## Requirements
- R1: A run is cut into pieces. Each piece goes from the current offset to the end of its PAGE_BYTES page, or covers the remaining count if that is smaller. Exactly one page-program command is sent per piece.
- R2: Every page-program command is preceded, since the previous one, by a write-enable command (opcode 0x06). The write-enable is sent on its own, in its own chip-select frame and with no other bytes.
- R3: A page-program frame carries opcode 0x02, then the three address bytes of the piece's offset with the most significant byte first, then the piece's stream bytes in arrival order. The offset wraps modulo 2^24.
- R4: After each piece the block sends frames holding opcode 0x70 followed by one read byte. It repeats these frames until bit 7 of the returned byte is 1. No write-enable or page-program command is sent before a ready status has been read.
- R5: If a ready status has bit 5, 4, 3 or 1 set, the block sends a one-byte frame with opcode 0x50, sends no further piece, and ends with done and prog_error=1. Bits 0 and 6 alone are not errors.
- R6: When every piece succeeds, done pulses for one cycle with prog_error=0. Exactly byte_count stream bytes are accepted in total.
- R7: A start with byte_count=0 gives done with prog_error=0 on the cycle after the start. Chip select stays high and no stream byte is accepted.
- R8: The link uses SPI mode 0 with the most significant bit first. SCLK is low whenever chip select is high. MOSI changes only while SCLK is low. Chip select stays high for at least GAP_CYC clock cycles between frames.
- R9: in_ready is asserted only inside the data phase of a page-program frame, with chip select low.
- R10: After reset, spi_cs_n=1, spi_sclk=0, busy=0, done=0 and in_ready=0. busy stays low whenever no run is in progress, and chip select is then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run, accepted while idle |
| start_offset | input | 24 | Flash byte offset of the first byte |
| byte_count | input | LEN_W | Number of bytes in the run |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Stream byte taken when high together with in_valid |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| prog_error | output | 1 | Result of the last run, 1 on a program error |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach is an error reported on a middle piece after several busy polls. That case must show the clear-flags frame, the abort and exactly the bytes taken before the abort. The bench's flash model therefore answers a chosen number of busy polls and then puts a chosen error byte on one chosen piece. The bench sweeps a small page size over offsets near and across page boundaries, lengths around one and two pages, and a start just below the top of the address space so that the offset wraps. The stream is throttled in some runs, so that a stalled byte inside the data phase is also covered.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WEN, ST_PP, ST_DATA, ST_POLL, ST_CLR, ST_GAP
  } seq_state_t;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_FSR  = 8'h70;
  localparam logic [7:0] OP_CLRF = 8'h50;
  localparam int         FSR_READY = 7;
  localparam logic [7:0] FSR_ERR_MASK = 8'h3A;
  localparam int         ADDR_BYTES = 3;
endpackage

// File: rtl/nor_spi_byte.sv
module nor_spi_byte #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       active,
  output logic       fin,
  output logic [7:0] rx
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div;
  logic [2:0]    bitn;
  logic [7:0]    txs;
  logic          tick;

  assign tick = active && (div == DW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div    <= '0;
      bitn   <= '0;
      txs    <= '0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      active <= 1'b0;
      fin    <= 1'b0;
      rx     <= '0;
    end else begin
      fin <= 1'b0;
      if (go && !active) begin
        active <= 1'b1;
        txs    <= tx;
        mosi   <= tx[7];
        div    <= '0;
        bitn   <= '0;
        sclk   <= 1'b0;
      end else if (active) begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              fin    <= 1'b1;
            end else begin
              bitn <= bitn + 1'b1;
              txs  <= {txs[6:0], 1'b0};
              mosi <= txs[6];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/nor_chunk_len.sv
module nor_chunk_len #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 24,
  parameter int PAGE_W = 8
) (
  input  logic [ADDR_W-1:0] ofs,
  input  logic [LEN_W-1:0]  left,
  output logic [LEN_W-1:0]  chunk
);
  logic [PAGE_W:0]  room;
  logic [LEN_W-1:0] room_ext;

  always_comb begin
    room     = (PAGE_W+1)'(1 << PAGE_W) - {1'b0, ofs[PAGE_W-1:0]};
    room_ext = LEN_W'(room);
    chunk    = (left < room_ext) ? left : room_ext;
  end
endmodule

// File: rtl/nor_page_prog.sv
module nor_page_prog #(
  parameter int LEN_W      = 24,
  parameter int PAGE_BYTES = 256,
  parameter int HALF_DIV   = 2,
  parameter int GAP_CYC    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [23:0]      start_offset,
  input  logic [LEN_W-1:0] byte_count,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             busy,
  output logic             done,
  output logic             prog_error,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  import nor_seq_pkg::*;

  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int GW     = $clog2(GAP_CYC + 1);

  seq_state_t        st, ret_st;
  logic [ADDR_W-1:0] ofs;
  logic [LEN_W-1:0]  left, data_left, chunk;
  logic [1:0]        idx;
  logic              kicked;
  logic [GW-1:0]     gap_cnt;
  logic [7:0]        tx_byte, rx_byte;
  logic              go, sh_active, sh_fin, cmd_st;

  nor_chunk_len #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)) u_len (
    .ofs(ofs), .left(left), .chunk(chunk)
  );

  nor_spi_byte #(.HALF_DIV(HALF_DIV)) u_sh (
    .clk(clk), .rst(rst), .go(go), .tx(tx_byte), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .active(sh_active), .fin(sh_fin),
    .rx(rx_byte)
  );

  always_comb begin
    case (st)
      ST_WEN:  tx_byte = OP_WREN;
      ST_PP:   tx_byte = (idx == 2'd0) ? OP_PROG
                         : ofs[8*(ADDR_BYTES - int'(idx)) +: 8];
      ST_DATA: tx_byte = in_data;
      ST_POLL: tx_byte = (idx == 2'd0) ? OP_FSR : 8'h00;
      ST_CLR:  tx_byte = OP_CLRF;
      default: tx_byte = 8'h00;
    endcase
    cmd_st   = (st == ST_WEN) || (st == ST_PP) || (st == ST_DATA) ||
               (st == ST_POLL) || (st == ST_CLR);
    in_ready = (st == ST_DATA) && !sh_active && !kicked;
    go       = cmd_st && !sh_active && !kicked && ((st != ST_DATA) || in_valid);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      ret_st     <= ST_IDLE;
      ofs        <= '0;
      left       <= '0;
      data_left  <= '0;
      idx        <= '0;
      kicked     <= 1'b0;
      gap_cnt    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      prog_error <= 1'b0;
      spi_cs_n   <= 1'b1;
    end else begin
      done <= 1'b0;
      if (go) kicked <= 1'b1;
      if (sh_fin) kicked <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          prog_error <= 1'b0;
          if (byte_count == '0) begin
            done <= 1'b1;
          end else begin
            busy     <= 1'b1;
            ofs      <= start_offset;
            left     <= byte_count;
            st       <= ST_WEN;
            spi_cs_n <= 1'b0;
          end
        end
        ST_GAP: begin
          if (gap_cnt == GW'(GAP_CYC - 1)) begin
            st <= ret_st;
            if (ret_st == ST_IDLE) begin
              done <= 1'b1;
              busy <= 1'b0;
            end else begin
              spi_cs_n <= 1'b0;
            end
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: if (sh_fin) begin
          case (st)
            ST_WEN: begin
              st <= ST_GAP; ret_st <= ST_PP;
            end
            ST_PP: begin
              if (idx == 2'(ADDR_BYTES)) begin
                st        <= ST_DATA;
                idx       <= '0;
                data_left <= chunk;
              end else begin
                idx <= idx + 1'b1;
              end
            end
            ST_DATA: begin
              data_left <= data_left - 1'b1;
              if (data_left == LEN_W'(1)) begin
                st <= ST_GAP; ret_st <= ST_POLL;
              end
            end
            ST_POLL: begin
              if (idx == 2'd0) begin
                idx <= 2'd1;
              end else begin
                st <= ST_GAP;
                if (!rx_byte[FSR_READY]) begin
                  ret_st <= ST_POLL;
                end else if ((rx_byte & FSR_ERR_MASK) != 8'h00) begin
                  ret_st <= ST_CLR;
                end else if (left == chunk) begin
                  ret_st <= ST_IDLE;
                end else begin
                  ret_st <= ST_WEN;
                  ofs    <= ofs + ADDR_W'(chunk);
                  left   <= left - chunk;
                end
              end
            end
            ST_CLR: begin
              st <= ST_GAP; ret_st <= ST_IDLE; prog_error <= 1'b1;
            end
            default: st <= ST_IDLE;
          endcase
          if (st != ST_PP && st != ST_DATA && !(st == ST_POLL && idx == 2'd0)) begin
            spi_cs_n <= 1'b1;
            gap_cnt  <= '0;
            idx      <= '0;
          end else if (st == ST_DATA && data_left == LEN_W'(1)) begin
            spi_cs_n <= 1'b1;
            gap_cnt  <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nor_page_prog_chk.sv
module nor_page_prog_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic in_ready,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_mosi
);
  // R8: clock idles low outside a frame
  a_r8_sclk_idle: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);
  // R8: data is steady across a rising clock edge
  a_r8_mosi_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sclk) |-> $stable(spi_mosi));
  // R8: chip select high for more than one cycle between frames
  a_r8_cs_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |=> spi_cs_n);
  // R9: stream accepted only inside a frame
  a_r9_ready_in_frame: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !spi_cs_n);
  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: no frame while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_cs_n);
endmodule

bind nor_page_prog nor_page_prog_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .in_ready(in_ready),
  .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/nor_page_prog_tb.sv
module nor_page_prog_tb;
  localparam int LEN_W = 24;
  localparam int P     = 16;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [23:0] start_offset = '0;
  logic [LEN_W-1:0] byte_count = '0;
  logic [7:0] in_data;
  logic in_valid, in_ready, busy, done, prog_error;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #5 clk = ~clk;

  nor_page_prog #(.LEN_W(LEN_W), .PAGE_BYTES(P), .HALF_DIV(1), .GAP_CYC(2)) u_dut (
    .clk(clk), .rst(rst), .start(start), .start_offset(start_offset),
    .byte_count(byte_count), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .busy(busy), .done(done), .prog_error(prog_error),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int errors = 0, checks = 0, cyc = 0;
  int hs_total = 0, hs_base = 0;
  logic stall_en = 1'b0;
  logic [7:0] seed = 8'h00;

  function automatic logic [7:0] pat(int i, logic [7:0] s);
    return 8'((i * 37) + 5 + int'(s));
  endfunction

  assign in_valid = !stall_en || ((cyc % 3) != 0);
  assign in_data  = pat(hs_total - hs_base, seed);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (in_valid && in_ready) hs_total <= hs_total + 1;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) if (cyc == LIMIT) begin
    errors++; checks++;
    $display("FAIL watchdog: run did not end, actual cycles=%0d expected<%0d", cyc, LIMIT);
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // flash model
  logic [7:0] fl_log [0:63];
  int nbytes = 0, bits = 0;
  logic [7:0] sh = 0, status = 8'h80, pend_err = 0;
  logic [23:0] m_ofs = 0;
  int m_len = 0, m_idx = 0, busy_polls = 0, dev_busy = 0, err_chunk = -1;
  logic [7:0] err_val = 0;
  int pp_cnt = 0, poll_cnt = 0, clr_cnt = 0, cmd_cnt = 0;
  int bad_len = 0, no_wen = 0, bad_addr = 0, bad_data = 0, bad_rdy = 0, bad_frame = 0;
  bit wen = 0, ready_seen = 1;

  always @(negedge spi_cs_n) begin bits = 0; nbytes = 0; spi_miso = 1'b0; end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    bits++;
    if (bits % 8 == 0 && nbytes < 64) begin fl_log[nbytes] = sh; nbytes++; end
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    if (nbytes >= 1 && fl_log[0] == 8'h70) spi_miso = status[7 - (bits % 8)];
    else spi_miso = 1'b0;
  end

  always @(posedge spi_cs_n) if (nbytes > 0) begin
    automatic logic [23:0] a, ea;
    automatic int len, el;
    cmd_cnt++;
    if (bits % 8 != 0) bad_frame++;
    case (fl_log[0])
      8'h06: begin
        if (nbytes != 1) bad_frame++;
        if (!ready_seen) bad_rdy++;
        wen = 1;
      end
      8'h02: begin
        if (!wen) no_wen++;
        if (!ready_seen) bad_rdy++;
        wen = 0; ready_seen = 0;
        a  = {fl_log[1], fl_log[2], fl_log[3]};
        ea = m_ofs + 24'(m_idx);
        if (a != ea) bad_addr++;
        len = nbytes - 4;
        el = P - int'(ea % P);
        if (m_len - m_idx < el) el = m_len - m_idx;
        if (len != el) bad_len++;
        for (int j = 0; j < len; j++)
          if (fl_log[4+j] != pat(m_idx + j, seed)) bad_data++;
        m_idx += len;
        pend_err = (pp_cnt == err_chunk) ? err_val : 8'h00;
        pp_cnt++;
        dev_busy = busy_polls;
        status = (dev_busy > 0) ? 8'h00 : (8'h80 | pend_err);
      end
      8'h70: begin
        if (nbytes != 2) bad_frame++;
        poll_cnt++;
        if (status[7]) ready_seen = 1;
        if (dev_busy > 0) dev_busy--;
        status = (dev_busy > 0) ? 8'h00 : (8'h80 | pend_err);
      end
      8'h50: begin
        if (nbytes != 1) bad_frame++;
        clr_cnt++; pend_err = 0; status = 8'h80;
      end
      default: bad_frame++;
    endcase
  end

  task automatic run(input logic [23:0] o, input int len, input int bp,
                     input int ec, input logic [7:0] ev, input bit stall);
    automatic int n_ch = 0, exp_pp, exp_hs, exp_clr, t = 0, wait_c = 0;
    automatic bit exp_err = 0, got_done = 0, got_err = 0;
    automatic int rem = len;
    automatic logic [23:0] c = o;
    automatic int hs_at_err = len;
    automatic string tg;
    while (rem > 0) begin
      t = P - int'(c % P);
      if (rem < t) t = rem;
      if (n_ch == ec && (ev & 8'h3A) != 0 && !exp_err) begin
        exp_err = 1; hs_at_err = (len - rem) + t;
      end
      n_ch++; rem -= t; c = c + 24'(t);
    end
    exp_pp  = exp_err ? ec + 1 : n_ch;
    exp_hs  = exp_err ? hs_at_err : len;
    exp_clr = exp_err ? 1 : 0;
    m_ofs = o; m_len = len; m_idx = 0; busy_polls = bp; err_chunk = ec; err_val = ev;
    pp_cnt = 0; poll_cnt = 0; clr_cnt = 0; cmd_cnt = 0; pend_err = 0; status = 8'h80;
    bad_len = 0; no_wen = 0; bad_addr = 0; bad_data = 0; bad_rdy = 0; bad_frame = 0;
    wen = 0; ready_seen = 1; dev_busy = 0;
    @(negedge clk);
    seed = o[7:0]; hs_base = hs_total; stall_en = stall;
    start = 1; start_offset = o; byte_count = LEN_W'(len);
    @(negedge clk);
    start = 0;
    if (done) begin got_done = 1; got_err = prog_error; end
    while (!got_done && wait_c < 30000) begin
      @(negedge clk); wait_c++;
      if (done) begin got_done = 1; got_err = prog_error; end
    end
    repeat (3) @(negedge clk);
    tg = $sformatf("ofs=%0h len=%0d bp=%0d ec=%0d ev=%0h", o, len, bp, ec, ev);
    if (len == 0) begin
      check(got_done && wait_c == 0, {"R7 immediate done ", tg}, wait_c, 0);
      check(cmd_cnt == 0, {"R7 no frames ", tg}, cmd_cnt, 0);
      check(hs_total - hs_base == 0, {"R7 no stream byte ", tg}, hs_total - hs_base, 0);
      check(got_err == 0, {"R7 result ", tg}, int'(got_err), 0);
    end else begin
      check(got_done, {"R6 done seen ", tg}, int'(got_done), 1);
      check(got_err == exp_err, {"R5 result flag ", tg}, int'(got_err), int'(exp_err));
      check(pp_cnt == exp_pp, {"R1 piece count ", tg}, pp_cnt, exp_pp);
      check(bad_len == 0, {"R1 piece length ", tg}, bad_len, 0);
      check(no_wen == 0, {"R2 write enable ", tg}, no_wen, 0);
      check(bad_addr == 0, {"R3 address ", tg}, bad_addr, 0);
      check(bad_data == 0, {"R3 data ", tg}, bad_data, 0);
      check(bad_rdy == 0, {"R4 command while busy ", tg}, bad_rdy, 0);
      check(poll_cnt == exp_pp * (bp + 1), {"R4 poll count ", tg}, poll_cnt, exp_pp * (bp + 1));
      check(clr_cnt == exp_clr, {"R5 clear flags ", tg}, clr_cnt, exp_clr);
      check(hs_total - hs_base == exp_hs, {"R6 R9 bytes taken ", tg}, hs_total - hs_base, exp_hs);
      check(bad_frame == 0, {"R8 framing ", tg}, bad_frame, 0);
    end
    check(!busy && spi_cs_n && !in_ready, {"R10 idle after run ", tg}, int'(busy), 0);
  endtask

  initial begin
    automatic logic [23:0] offs [6] = '{24'h0, 24'h1, 24'h7, 24'hF, 24'h10, 24'hFFFFF9};
    automatic int lens [8] = '{0, 1, 2, 15, 16, 17, 31, 33};
    automatic logic [7:0] evs [6] = '{8'h20, 8'h10, 8'h08, 8'h02, 8'h01, 8'h40};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(spi_cs_n == 1 && spi_sclk == 0, "R10 reset link idle", int'(spi_cs_n), 1);
    check(!busy && !done && !in_ready, "R10 reset outputs low", int'(busy), 0);
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 8; j++)
        run(offs[i], lens[j], (i + j) % 3, -1, 8'h00, (j % 2) == 1);
    for (int k = 0; k < 6; k++)
      run(24'h5, 40, k % 3, 1, evs[k], k[0]);
    run(24'h5, 40, 2, 0, 8'h3A, 1'b0);
    run(24'h3C, 20, 1, 1, 8'h10, 1'b1);
    summary();
    $finish;
  end
endmodule